// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block looks at the 48-bit destination address of an incoming frame and decides whether the receiver keeps the frame. It first sorts the address into one of three classes: broadcast, multicast or unicast. It then tries three stages in turn. The first is a promiscuous bit for each class. The second is a bank of sixteen exact-match address entries, each with its own valid bit. The third is a 4096-bit multicast hash table, which is indexed by a 12-bit window taken from the last two address bytes. Software chooses the window position.

An address enters on a valid/ready stream. One cycle after the handshake, a result appears on a second valid/ready stream. The result carries the accept decision, the class, and the lowest-numbered exact entry that matched. A statistics unit downstream can use that index. The entry bank and the hash table are loaded through a plain single-cycle register write port.

Back-pressure works as follows. The input is ready whenever the output register is empty, or is being emptied in the same cycle. While the result is valid and not taken, it stays frozen and no new address is accepted. The block therefore holds at most one result and loses none.

Top module: `dest_addr_filter`

## Requirements
- R1: Byte k of the address is `in_da[8k+7:8k]`, and byte 0 is the first byte on the wire. The class is reported on `res_type` with this encoding:
  - an all-ones address is broadcast, `2'b10`;
  - any other address with `in_da[0]` set is multicast, `2'b01`;
  - every other address is unicast, `2'b00`.
- R2: A broadcast address is accepted when `bcast_accept` is high.
- R3: A multicast address is accepted when `mcast_promisc` is high.
- R4: A unicast address is accepted when `ucast_promisc` is high. This bit has no effect on broadcast or multicast addresses.
- R5: When the promiscuous bit for the address's class is low, the exact-match and hash stages still decide. This holds for all three classes, broadcast included.
- R6: Entry i is written through the register port in two words:
  - `wr_addr = 2i` writes address bytes 0..3, with byte k at bits 8k+7:8k;
  - `wr_addr = 2i+1` writes bytes 4 and 5 at bits 15:0, and the entry's valid bit at bit 31.
  An entry only matches when its valid bit is set.
- R7: When one or more valid entries equal the address, `res_hit` is 1 and `res_index` gives the lowest matching entry number. When no valid entry equals the address, `res_hit` is 0 and `res_index` is 0.
- R8: The hash is formed in three steps:
  - take `{byte5, byte4}`;
  - shift it right by 4, 3, 2 or 0 for `hash_sel` = 0, 1, 2 or 3;
  - keep the low 12 bits.
  Hash table word w is written at `wr_addr = 128 + w`. Bit h of the table is bit h[4:0] of word h[11:5]. A set bit accepts the frame.
- R9: An address accepted by no stage gives `res_accept = 0`.
- R10: The stream handshake follows these rules:
  - `in_ready` is high exactly when `res_valid` is low or `res_ready` is high;
  - the result is valid in the cycle after an input handshake;
  - while `res_valid` is high and `res_ready` is low, every result field holds its value.
- R11: Reset clears `res_valid`, every entry (valid bit included) and every hash table bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Destination address offered |
| in_ready | output | 1 | Block can take an address |
| in_da | input | 48 | Destination address, byte 0 in bits 7:0 |
| bcast_accept | input | 1 | Accept all broadcast frames |
| mcast_promisc | input | 1 | Accept all multicast frames |
| ucast_promisc | input | 1 | Accept all unicast frames |
| hash_sel | input | 2 | Hash window selection |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table word address |
| wr_data | input | 32 | Table write data |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_accept | output | 1 | Frame accepted |
| res_type | output | 2 | Address class |
| res_hit | output | 1 | An exact entry matched |
| res_index | output | 4 | Lowest matching entry |

## Verification
Every result field is registered once. The result for an address becomes visible in the cycle after its input handshake, and it stays there until the consumer takes it. The driver computes the expected result when it offers an address and queues it. The monitor samples one time unit after the falling edge, then pops and compares an item only in a cycle where both `res_valid` and `res_ready` are high. Because each item is compared once per transfer, results are checked in the order they leave the block, and a stalled result is compared only at its transfer. The monitor also confirms that a stalled result is unchanged one cycle later. Table writes reach storage at the next rising edge, and the driver only offers addresses after its writes, so each expected value uses the table contents that the lookup saw.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int DAF_HASH_BITS = 12;
  localparam int DAF_WORD_W    = 32;
  localparam int DAF_BIT_SEL_W = $clog2(DAF_WORD_W);

  typedef enum logic [1:0] {
    PKT_UCAST = 2'b00,
    PKT_MCAST = 2'b01,
    PKT_BCAST = 2'b10
  } pkt_class_e;

  function automatic pkt_class_e classify(input logic [47:0] da);
    if (&da)       return PKT_BCAST;
    else if (da[0]) return PKT_MCAST;
    else           return PKT_UCAST;
  endfunction

  // Window over {byte5, byte4}; selection picks the right shift.
  function automatic logic [DAF_HASH_BITS-1:0] hash_of(input logic [15:0] src,
                                                       input logic [1:0]  sel);
    logic [15:0] sh;
    unique case (sel)
      2'd0:    sh = src >> 4;
      2'd1:    sh = src >> 3;
      2'd2:    sh = src >> 2;
      default: sh = src;
    endcase
    return sh[DAF_HASH_BITS-1:0];
  endfunction

endpackage

// File: rtl/daf_exact_bank.sv
module daf_exact_bank #(
  parameter int NUM_ENTRIES = 16,
  parameter int AW          = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [47:0]      da,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Entry words occupy the bottom of the map: upper address bits zero.
  logic                region;
  logic [IDX_W-1:0]    wr_ent;
  logic                wr_high;
  logic [NUM_ENTRIES-1:0] match;
  logic                unused_hi_bits;

  assign region  = (wr_addr[AW-1:IDX_W+1] == '0);
  assign wr_ent  = wr_addr[IDX_W:1];
  assign wr_high = wr_addr[0];
  assign unused_hi_bits = ^wr_data[30:16];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        vld_q;
    logic        sel;

    assign sel = wr_en && region && (wr_ent == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        vld_q <= 1'b0;
      end else if (sel) begin
        if (wr_high) begin
          hi_q  <= wr_data[15:0];
          vld_q <= wr_data[31];
        end else begin
          lo_q  <= wr_data;
        end
      end
    end

    assign match[g] = vld_q && ({hi_q, lo_q} == da);
  end

  // Lowest-numbered match wins: scan downward so low entries overwrite.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table
  import daf_pkg::*;
#(
  parameter int AW          = 8,
  localparam int WORDS      = (1 << DAF_HASH_BITS) / DAF_WORD_W,
  localparam int WSEL_W     = $clog2(WORDS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [31:0]              wr_data,
  input  logic [DAF_HASH_BITS-1:0] hash,
  output logic                     bit_set
);

  logic [DAF_WORD_W-1:0] tbl_q [WORDS];
  logic                  wr_sel;
  logic [WSEL_W-1:0]     wr_word;

  // Hash words live in the upper half of the map.
  assign wr_sel  = wr_en && wr_addr[AW-1];
  assign wr_word = wr_addr[WSEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) tbl_q[w] <= '0;
    end else if (wr_sel) begin
      tbl_q[wr_word] <= wr_data;
    end
  end

  logic [DAF_WORD_W-1:0] rd_word;
  assign rd_word = tbl_q[hash[DAF_HASH_BITS-1:DAF_BIT_SEL_W]];
  assign bit_set = rd_word[hash[DAF_BIT_SEL_W-1:0]];

endmodule

// File: rtl/daf_result_stage.sv
module daf_result_stage #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             accept_d,
  input  logic [1:0]       type_d,
  input  logic             hit_d,
  input  logic [IDX_W-1:0] index_d,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_accept,
  output logic [1:0]       res_type,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index
);

  logic fire;
  assign in_ready = !res_valid || res_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
    end else if (fire) begin
      res_valid <= 1'b1;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_accept <= 1'b0;
      res_type   <= '0;
      res_hit    <= 1'b0;
      res_index  <= '0;
    end else if (fire) begin
      res_accept <= accept_d;
      res_type   <= type_d;
      res_hit    <= hit_d;
      res_index  <= index_d;
    end
  end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int WORDS      = (1 << DAF_HASH_BITS) / DAF_WORD_W,
  localparam int AW         = $clog2(WORDS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [47:0]      in_da,
  input  logic             bcast_accept,
  input  logic             mcast_promisc,
  input  logic             ucast_promisc,
  input  logic [1:0]       hash_sel,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_accept,
  output logic [1:0]       res_type,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_index
);

  pkt_class_e              cls;
  logic                    promisc_hit;
  logic                    exact_hit;
  logic [IDX_W-1:0]        exact_idx;
  logic [DAF_HASH_BITS-1:0] hash;
  logic                    hash_hit;
  logic                    accept_d;

  assign cls  = classify(in_da);
  assign hash = hash_of(in_da[47:32], hash_sel);

  always_comb begin
    unique case (cls)
      PKT_BCAST: promisc_hit = bcast_accept;
      PKT_MCAST: promisc_hit = mcast_promisc;
      default:   promisc_hit = ucast_promisc;
    endcase
  end

  daf_exact_bank #(.NUM_ENTRIES(NUM_ENTRIES), .AW(AW)) u_exact (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .da      (in_da),
    .hit     (exact_hit),
    .idx     (exact_idx)
  );

  daf_hash_table #(.AW(AW)) u_hash (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hash    (hash),
    .bit_set (hash_hit)
  );

  assign accept_d = promisc_hit || exact_hit || hash_hit;

  daf_result_stage #(.IDX_W(IDX_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .accept_d   (accept_d),
    .type_d     (cls),
    .hit_d      (exact_hit),
    .index_d    (exact_idx),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_accept (res_accept),
    .res_type   (res_type),
    .res_hit    (res_hit),
    .res_index  (res_index)
  );

endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [47:0]      in_da,
  input logic             bcast_accept,
  input logic             mcast_promisc,
  input logic             ucast_promisc,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_accept,
  input logic [1:0]       res_type,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_index
);

  logic fire;
  logic is_bc;
  assign fire  = in_valid && in_ready;
  assign is_bc = &in_da;

  AST_BCAST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_bc) |=> (res_valid && res_type == 2'b10)); // R1

  AST_BCAST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && is_bc && bcast_accept) |=> res_accept); // R2

  AST_MCAST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_bc && in_da[0] && mcast_promisc) |=> res_accept); // R3

  AST_UCAST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_da[0] && ucast_promisc) |=> (res_accept && res_type == 2'b00)); // R4

  AST_NO_HIT_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_index == '0)); // R7

  AST_FIRE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable({res_accept, res_type, res_hit, res_index}))); // R10

endmodule

bind dest_addr_filter daf_checker #(.IDX_W(IDX_W)) u_daf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_da         (in_da),
  .bcast_accept  (bcast_accept),
  .mcast_promisc (mcast_promisc),
  .ucast_promisc (ucast_promisc),
  .res_valid     (res_valid),
  .res_ready     (res_ready),
  .res_accept    (res_accept),
  .res_type      (res_type),
  .res_hit       (res_hit),
  .res_index     (res_index)
);

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;

  localparam int NE = 16;

  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready;
  logic [47:0] in_da;
  logic        bcast_accept, mcast_promisc, ucast_promisc;
  logic [1:0]  hash_sel;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic        res_valid, res_ready, res_accept, res_hit;
  logic [1:0]  res_type;
  logic [3:0]  res_index;

  dest_addr_filter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_da(in_da), .bcast_accept(bcast_accept), .mcast_promisc(mcast_promisc),
    .ucast_promisc(ucast_promisc), .hash_sel(hash_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .res_valid(res_valid),
    .res_ready(res_ready), .res_accept(res_accept), .res_type(res_type),
    .res_hit(res_hit), .res_index(res_index)
  );

  typedef struct packed {
    logic       acc;
    logic [1:0] ty;
    logic       hit;
    logic [3:0] idx;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  logic [31:0] m_lo [NE];
  logic [31:0] m_hi [NE];
  logic [31:0] m_hash [128];
  int checks = 0;
  int fails  = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [47:0] da, input logic ba, mp, up,
                                 input logic [1:0] hs);
    exp_t e;
    logic [15:0] src;
    logic [11:0] h;
    logic prom;
    e = '0;
    if (&da) e.ty = 2'b10;
    else if (da[0]) e.ty = 2'b01;
    else e.ty = 2'b00;
    prom = (e.ty == 2'b10 && ba) || (e.ty == 2'b01 && mp) || (e.ty == 2'b00 && up);
    for (int i = 0; i < NE; i++) begin
      if (!e.hit && m_hi[i][31] && {m_hi[i][15:0], m_lo[i]} == da) begin
        e.hit = 1'b1;
        e.idx = 4'(i);
      end
    end
    src = da[47:32];
    case (hs)
      2'd0: h = 12'(src >> 4);
      2'd1: h = 12'(src >> 3);
      2'd2: h = 12'(src >> 2);
      default: h = 12'(src);
    endcase
    e.acc = prom || e.hit || m_hash[h[11:5]][h[4:0]];
    return e;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a[7]) m_hash[a[6:0]] = d;
    else if (a < 8'd32) begin
      if (a[0]) m_hi[a[4:1]] = d; else m_lo[a[4:1]] = d;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_entry(input int i, input logic [47:0] da, input logic v);
    wr(8'(2 * i), da[31:0]);
    wr(8'(2 * i + 1), {v, 15'd0, da[47:32]});
  endtask

  task automatic send(input logic [47:0] da, input logic ba, mp, up,
                      input logic [1:0] hs, input string req);
    bit ok;
    @(negedge clk);
    exp_q.push_back(model(da, ba, mp, up, hs));
    tag_q.push_back(req);
    in_valid = 1'b1; in_da = da;
    bcast_accept = ba; mcast_promisc = mp; ucast_promisc = up; hash_sel = hs;
    forever begin
      #1 ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: drives res_ready, pops and compares at each output transfer.
  initial begin : monitor
    exp_t e, prev;
    string r;
    bit held;
    held = 1'b0;
    prev = '0;
    res_ready = 1'b1;
    forever begin
      @(negedge clk);
      res_ready = stall_mode ? 1'($urandom_range(0, 1)) : 1'b1;
      #1;
      if (rst_n && held)
        check({res_valid, res_accept, res_type, res_hit, res_index} == {1'b1, prev},
              "R10 stall hold", $sformatf("%b", {res_accept, res_type, res_hit, res_index}),
              $sformatf("%b", prev));
      held = rst_n && res_valid && !res_ready;
      prev = {res_accept, res_type, res_hit, res_index};
      if (rst_n) check(in_ready == (!res_valid || res_ready), "R10 in_ready",
                       $sformatf("%b", in_ready), $sformatf("%b", !res_valid || res_ready));
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected result", "extra", "none");
        end else begin
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check({res_accept, res_type, res_hit, res_index} == e, r,
                $sformatf("acc=%b ty=%b hit=%b idx=%0d", res_accept, res_type, res_hit, res_index),
                $sformatf("acc=%b ty=%b hit=%b idx=%0d", e.acc, e.ty, e.hit, e.idx));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin : driver
    logic [47:0] a;
    for (int i = 0; i < NE; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    for (int i = 0; i < 128; i++) m_hash[i] = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_da = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    bcast_accept = 1'b0; mcast_promisc = 1'b0; ucast_promisc = 1'b0; hash_sel = '0;
    repeat (3) @(negedge clk);
    #1;
    check(res_valid == 1'b0, "R11 reset valid", $sformatf("%b", res_valid), "0");
    rst_n = 1'b1;
    // R11: empty tables reject everything with promisc off
    send(48'h0000_0000_0000, 0, 0, 0, 2'd0, "R11 cleared tables");
    // R1/R2/R9 broadcast
    send({48{1'b1}}, 1, 0, 0, 2'd0, "R2 bcast accept");
    send({48{1'b1}}, 0, 1, 1, 2'd0, "R9 bcast reject");
    // R3/R4 promiscuous
    send(48'h0A0B_0C0D_0E01, 0, 1, 0, 2'd1, "R3 mcast promisc");
    send(48'h0A0B_0C0D_0E01, 0, 0, 1, 2'd1, "R4 ucast promisc ignored for mcast");
    send(48'h0A0B_0C0D_0E02, 0, 0, 1, 2'd1, "R4 ucast promisc");
    send(48'h0A0B_0C0D_0E02, 1, 1, 0, 2'd1, "R9 ucast reject");
    // R5: broadcast via hash (word 127 bit 31 for window 0)
    wr(8'd255, 32'h8000_0000);
    send({48{1'b1}}, 0, 0, 0, 2'd0, "R5 bcast via hash");
    send({48{1'b1}}, 0, 0, 0, 2'd3, "R8 bcast other window");
    // R6/R7 exact entries
    set_entry(5, 48'h6655_4433_2210, 1'b1);
    send(48'h6655_4433_2210, 0, 0, 0, 2'd0, "R6 exact match");
    set_entry(5, 48'h6655_4433_2210, 1'b0);
    send(48'h6655_4433_2210, 0, 0, 0, 2'd0, "R6 invalid entry ignored");
    set_entry(9, 48'h1111_2222_3335, 1'b1);
    set_entry(3, 48'h1111_2222_3335, 1'b1);
    send(48'h1111_2222_3335, 0, 0, 0, 2'd0, "R7 lowest index");
    set_entry(15, {48{1'b1}}, 1'b1);
    send({48{1'b1}}, 0, 0, 0, 2'd2, "R5 bcast via exact");
    // R8 hash windows: src 0x1234, only window 2 (0x48D) set
    wr(8'(128 + 36), 32'h0000_2000);
    for (int s = 0; s < 4; s++)
      send(48'h1234_0000_0002, 0, 0, 0, 2'(s), "R8 hash window");
    // Random traffic with back-pressure
    stall_mode = 1'b1;
    for (int i = 0; i < 6; i++) set_entry(i, {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFE, 1'($urandom_range(0, 1)));
    for (int i = 0; i < 8; i++) wr(8'(128 + $urandom_range(0, 127)), $urandom());
    for (int i = 0; i < 60; i++) begin
      case ($urandom_range(0, 3))
        0: a = {m_hi[$urandom_range(0, 5)][15:0], m_lo[$urandom_range(0, 5)]};
        1: a = {48{1'b1}};
        default: a = {$urandom(), $urandom()};
      endcase
      send(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "R10 random stream");
    end
    while (exp_q.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule